// File: doc/BRIEF.md
# Dual-Space Upper Data Memory Decoder

This block holds a byte-wide on-chip data store whose upper half overlaps a separate special-register space. Both stores answer to addresses 80h through FFh, but they are physically distinct. The address alone does not pick the store; the addressing mode of each access does.

Addresses 00h to 7Fh always reach the lower RAM bank, whatever the mode. Above 7Fh, a direct access goes to the special-register space, and an indirect access goes to the upper RAM bank. Stack pushes and pops are indirect accesses, so they land in upper RAM. A small example set of special registers is implemented. Unimplemented special-register addresses read as 00h and ignore writes.

The decoded target appears at once on three select lines. Read data is registered and appears one clock after the read strobe.

Top module: `dual_space_dmem`

## Requirements
- R1: A synchronous active-high reset clears `rdata` to 00h. It sets the implemented special registers at 80h, 90h, A0h and B0h to FFh, and those at E0h and F0h to 00h.
- R2: With address bit 7 low (00h–7Fh), an access reaches the lower RAM in both modes. A byte written in one mode reads back in the other mode, and `sel_lower` is high.
- R3: With address bit 7 high and `indirect` low, an access reaches the special-register space and `sel_spec` is high.
- R4: With address bit 7 high and `indirect` high (this includes stack pushes and pops), an access reaches the upper RAM bank and `sel_upper` is high.
- R5: A direct write to A0h changes only the special register at A0h. An indirect write to A0h changes only RAM byte A0h. Each then reads back its own value.
- R6: A direct read of an unimplemented special-register address returns 00h. A direct write there leaves every RAM byte and every implemented special register unchanged.
- R7: Read data appears on `rdata` at the clock edge that ends the cycle in which `rd_en` is high. A read in the cycle right after a write to the same location returns the new value.
- R8: When `rd_en` and `wr_en` are both high for the same location, `rdata` shows the contents from before the write.
- R9: While `rd_en` is low, `rdata` keeps its last value, even when writes take place.
- R10: During a cycle with `rd_en` or `wr_en` high, exactly one select line is high, in the same cycle. With both strobes low, all select lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| indirect | input | 1 | 1 = indirect (pointer or stack) access, 0 = direct access |
| rdata | output | 8 | Registered read data |
| sel_lower | output | 1 | Current access targets the lower RAM bank |
| sel_upper | output | 1 | Current access targets the upper RAM bank |
| sel_spec | output | 1 | Current access targets the special-register space |

## Verification
On every cycle, the bound assertions check the routing rule: which select line a given address half and mode must raise, that at most one select line is high, that all are quiet while idle, and that `rdata` holds when no read is issued.

Some behaviour only the bench scenarios can show. These are the separation of the two stores at the same address, the reset contents, the 00h answer and the absence of side effects for unimplemented registers, and read-before-write ordering. Each of these needs data written by one access and observed through a later read.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

    localparam int AW       = 8;
    localparam int DW       = 8;
    localparam int NUM_SPEC = 6;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_LOWER = 2'd1,
        TGT_UPPER = 2'd2,
        TGT_SPEC  = 2'd3
    } target_e;

    typedef struct packed {
        target_e tgt;
        logic    rd;
        logic    wr;
    } route_t;

    // Address of implemented special register number idx.
    function automatic logic [7:0] spec_addr(input int idx);
        case (idx)
            0:       return 8'h80;
            1:       return 8'h90;
            2:       return 8'hA0;
            3:       return 8'hB0;
            4:       return 8'hE0;
            default: return 8'hF0;
        endcase
    endfunction

    // Reset value: the four port-like registers come up all ones.
    function automatic logic [7:0] spec_reset(input int idx);
        return (idx < 4) ? 8'hFF : 8'h00;
    endfunction

    // Target selection: upper half picks a store by addressing mode.
    function automatic route_t route(input logic hi_half, input logic ind,
                                     input logic rd, input logic wr);
        route_t r;
        r.rd = rd;
        r.wr = wr;
        if (!(rd || wr))   r.tgt = TGT_NONE;
        else if (!hi_half) r.tgt = TGT_LOWER;
        else if (ind)      r.tgt = TGT_UPPER;
        else               r.tgt = TGT_SPEC;
        return r;
    endfunction

endpackage

// File: rtl/dspace_decode.sv
module dspace_decode
    import dspace_pkg::*;
(
    input  logic   hi_half,
    input  logic   indirect,
    input  logic   rd_en,
    input  logic   wr_en,
    output route_t rt,
    output logic   sel_lower,
    output logic   sel_upper,
    output logic   sel_spec
);

    always_comb begin
        rt        = route(hi_half, indirect, rd_en, wr_en);
        sel_lower = (rt.tgt == TGT_LOWER);
        sel_upper = (rt.tgt == TGT_UPPER);
        sel_spec  = (rt.tgt == TGT_SPEC);
    end

endmodule

// File: rtl/dspace_ram_bank.sv
module dspace_ram_bank #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Registered read; a same-cycle write is not yet visible.
    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[addr];
    end

endmodule

// File: rtl/dspace_spec_file.sv
module dspace_spec_file
    import dspace_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [NUM_SPEC-1:0] hit;
    logic [DW-1:0]       masked [NUM_SPEC];
    logic [DW-1:0]       rd_mux;

    for (genvar i = 0; i < NUM_SPEC; i++) begin : g_reg
        logic [DW-1:0] val_q;

        assign hit[i] = (addr == AW'(spec_addr(i)));

        always_ff @(posedge clk) begin
            if (rst)                val_q <= DW'(spec_reset(i));
            else if (we && hit[i])  val_q <= wdata;
        end

        assign masked[i] = hit[i] ? val_q : '0;
    end

    // Unmapped addresses hit nothing and so read back zero.
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_SPEC; k++) rd_mux = rd_mux | masked[k];
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= rd_mux;
    end

endmodule

// File: rtl/dual_space_dmem.sv
module dual_space_dmem
    import dspace_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              indirect,
    output logic [DATA_W-1:0] rdata,
    output logic              sel_lower,
    output logic              sel_upper,
    output logic              sel_spec
);

    localparam int BANK_AW   = ADDR_W - 1;
    localparam int NUM_BANKS = 2;

    route_t      rt;
    logic [DATA_W-1:0] bank_q [NUM_BANKS];
    logic [DATA_W-1:0] spec_q;
    target_e     src_q;

    dspace_decode u_dec (
        .hi_half   (addr[ADDR_W-1]),
        .indirect  (indirect),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .rt        (rt),
        .sel_lower (sel_lower),
        .sel_upper (sel_upper),
        .sel_spec  (sel_spec)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam target_e BANK_TGT = (b == 0) ? TGT_LOWER : TGT_UPPER;
        logic hit;
        assign hit = (rt.tgt == BANK_TGT);

        dspace_ram_bank #(.AW(BANK_AW), .DW(DATA_W)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (rt.wr & hit),
            .re    (rt.rd & hit),
            .addr  (addr[BANK_AW-1:0]),
            .wdata (wdata),
            .rdata (bank_q[b])
        );
    end

    dspace_spec_file #(.AW(ADDR_W), .DW(DATA_W)) u_spec (
        .clk   (clk),
        .rst   (rst),
        .we    (rt.wr & (rt.tgt == TGT_SPEC)),
        .re    (rt.rd & (rt.tgt == TGT_SPEC)),
        .addr  (addr),
        .wdata (wdata),
        .rdata (spec_q)
    );

    // Remember which store answered the last read.
    always_ff @(posedge clk) begin
        if (rst)        src_q <= TGT_NONE;
        else if (rd_en) src_q <= rt.tgt;
    end

    always_comb begin
        case (src_q)
            TGT_LOWER: rdata = bank_q[0];
            TGT_UPPER: rdata = bank_q[1];
            TGT_SPEC:  rdata = spec_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/dual_space_dmem_chk.sv
module dual_space_dmem_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              indirect,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] rdata,
    input logic              sel_lower,
    input logic              sel_upper,
    input logic              sel_spec
);

    logic busy;
    assign busy = rd_en | wr_en;

    AST_LOWER_ANY_MODE: assert property (@(posedge clk) disable iff (rst)
        (busy && !addr[ADDR_W-1]) |-> sel_lower); // R2

    AST_DIRECT_TO_SPEC: assert property (@(posedge clk) disable iff (rst)
        (busy && addr[ADDR_W-1] && !indirect) |-> sel_spec); // R3

    AST_INDIRECT_TO_UPPER: assert property (@(posedge clk) disable iff (rst)
        (busy && addr[ADDR_W-1] && indirect) |-> sel_upper); // R4

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_lower, sel_upper, sel_spec})); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(sel_lower || sel_upper || sel_spec)); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R9

endmodule

bind dual_space_dmem dual_space_dmem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dual_space_dmem_tb_top.sv
`timescale 1ns/1ps
module dual_space_dmem_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       indirect = 1'b0;
    logic [7:0] rdata;
    logic       sel_lower, sel_upper, sel_spec;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dual_space_dmem dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .indirect(indirect),
        .rdata(rdata), .sel_lower(sel_lower), .sel_upper(sel_upper),
        .sel_spec(sel_spec)
    );

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic       ind;
        logic [7:0] a;
        logic [7:0] d;
        logic       chk;
        logic [7:0] expv;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,8'h10,8'h11,1'b0,8'h00,4'd2},  // R2 direct write low
        '{1'b0,1'b1,1'b1,8'h10,8'h00,1'b1,8'h11,4'd2},  // R2 indirect read back
        '{1'b1,1'b0,1'b1,8'h20,8'h22,1'b0,8'h00,4'd2},  // R2 indirect write low
        '{1'b0,1'b1,1'b0,8'h20,8'h00,1'b1,8'h22,4'd2},  // R2 direct read back
        '{1'b1,1'b0,1'b1,8'h85,8'h3C,1'b0,8'h00,4'd6},  // R6 setup upper RAM 85h
        '{1'b1,1'b0,1'b0,8'hA0,8'h5A,1'b0,8'h00,4'd5},  // R5 direct write A0h
        '{1'b1,1'b0,1'b1,8'hA0,8'hC3,1'b0,8'h00,4'd5},  // R5 indirect write A0h
        '{1'b0,1'b1,1'b0,8'hA0,8'h00,1'b1,8'h5A,4'd5},  // R5 register kept
        '{1'b0,1'b1,1'b1,8'hA0,8'h00,1'b1,8'hC3,4'd5},  // R5 RAM kept
        '{1'b1,1'b0,1'b1,8'hFF,8'h77,1'b0,8'h00,4'd4},  // R4 stack push FFh
        '{1'b0,1'b1,1'b1,8'hFF,8'h00,1'b1,8'h77,4'd4},  // R4 stack pop FFh
        '{1'b0,1'b1,1'b0,8'hFF,8'h00,1'b1,8'h00,4'd3},  // R3 direct FFh misses RAM
        '{1'b1,1'b0,1'b0,8'h85,8'hAA,1'b0,8'h00,4'd6},  // R6 unmapped write
        '{1'b0,1'b1,1'b0,8'h85,8'h00,1'b1,8'h00,4'd6},  // R6 unmapped reads zero
        '{1'b0,1'b1,1'b1,8'h85,8'h00,1'b1,8'h3C,4'd6},  // R6 RAM untouched
        '{1'b0,1'b1,1'b0,8'h80,8'h00,1'b1,8'hFF,4'd6},  // R6 register untouched
        '{1'b1,1'b0,1'b0,8'hE0,8'h0F,1'b0,8'h00,4'd3},  // R3 direct write E0h
        '{1'b0,1'b1,1'b0,8'hE0,8'h00,1'b1,8'h0F,4'd7},  // R7 next-cycle read
        '{1'b1,1'b1,1'b1,8'hFF,8'h01,1'b1,8'h77,4'd8},  // R8 read-before-write
        '{1'b0,1'b1,1'b1,8'hFF,8'h00,1'b1,8'h01,4'd7},  // R7 new value visible
        '{1'b1,1'b0,1'b0,8'h7F,8'h5E,1'b0,8'h00,4'd2},  // R2 boundary 7Fh
        '{1'b0,1'b1,1'b1,8'h7F,8'h00,1'b1,8'h5E,4'd2}   // R2 boundary read
    };

    task automatic check(input string req, input logic [7:0] act,
                         input logic [7:0] expv, input string what);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, expv);
        end
    endtask

    // Expected select lines {lower, upper, spec}, from R2/R3/R4/R10.
    function automatic logic [2:0] exp_sel(input logic w, input logic r,
                                           input logic i, input logic [7:0] a);
        if (!(w || r)) return 3'b000;
        if (!a[7])     return 3'b100;
        return i ? 3'b010 : 3'b001;
    endfunction

    // One access cycle: drive at negedge, check selects, return after posedge.
    task automatic cycle(input logic w, input logic r, input logic i,
                         input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; indirect = i; addr = a; wdata = d;
        #1;
        check("R10", {5'b0, sel_lower, sel_upper, sel_spec},
              {5'b0, exp_sel(w, r, i, a)}, "select lines");
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        #1;
        check("R1", rdata, 8'h00, "rdata after reset");

        // R1: reset contents of the implemented special registers
        for (int k = 0; k < 6; k++) begin
            logic [7:0] ra;
            ra = (k < 4) ? 8'h80 + 8'(k * 16) : 8'hE0 + 8'((k - 4) * 16);
            cycle(1'b0, 1'b1, 1'b0, ra, 8'h00);
            check("R1", rdata, (k < 4) ? 8'hFF : 8'h00, "reset value");
        end

        for (int v = 0; v < NV; v++) begin
            cycle(VECS[v].wr, VECS[v].rd, VECS[v].ind, VECS[v].a, VECS[v].d);
            if (VECS[v].chk)
                check($sformatf("R%0d", VECS[v].req), rdata, VECS[v].expv,
                      $sformatf("vector %0d", v));
        end

        // R9: rdata holds through a write and idle cycles
        cycle(1'b0, 1'b1, 1'b0, 8'hA0, 8'h00);
        check("R9", rdata, 8'h5A, "hold setup read");
        cycle(1'b1, 1'b0, 1'b1, 8'h30, 8'h99);
        check("R9", rdata, 8'h5A, "hold across write");
        for (int k = 0; k < 3; k++) begin
            cycle(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
            check("R9", rdata, 8'h5A, "hold while idle");
        end

        // R1: reset restores a modified special register
        cycle(1'b1, 1'b0, 1'b0, 8'hA0, 8'h12);
        do_reset();
        #1;
        check("R1", rdata, 8'h00, "rdata after second reset");
        cycle(1'b0, 1'b1, 1'b0, 8'hA0, 8'h00);
        check("R1", rdata, 8'hFF, "A0h restored");

        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule